// File: doc/BRIEF.md
# Programmable Sum-of-Products Macrocell with Shared Expanders

This block is one programmable-array macrocell. A fuse-programmed AND plane builds product terms from the true and complemented forms of four data inputs. A small fixed OR gate adds exactly three of these product terms. A programmable inverter follows the OR gate. The result is sent out either straight from the logic or through a register clocked by the macrocell clock.

Two shared expander terms widen what the macrocell can implement. Each expander is an AND of selected input literals. That AND is inverted and fed back into the plane as an extra pair of literals. The main product terms can therefore form products of products. The cost is a second pass through the plane, which is modelled as two stages of evaluation: expanders first, then product terms. A function that needs more than three product terms can still fit in two ways: by factoring through expanders, or by building the complement and inverting it.

The whole setting is held in a 54-bit configuration chain that is loaded serially. The bit shifted in first ends up in the most significant position.

Top module: `mc_macrocell`

## Requirements
- R1: While `rst_n` is low at a rising edge, the configuration chain and the output register clear. With a cleared configuration `f_out` is 0 for every `din`.
- R2: At each rising edge with `cfg_shift` high, the chain moves one place toward its MSB and takes `cfg_din` into bit 0. With `cfg_shift` low, the chain holds whatever `cfg_din` does. Chain layout: bits 53..18 are the product-term masks (term k at 18+12k, 12 bits each), bits 17..2 are the expander masks (expander j at 2+8j, 8 bits each), bit 1 is the output invert, and bit 0 selects the registered output.
- R3: Literal index 2i is `din[i]` and index 2i+1 is its complement, for i = 0..3. Indices 8 and 9 are expander 0 and its complement. Indices 10 and 11 are expander 1 and its complement. A product term is the AND of the literals whose mask bits are 1. A product term whose mask is all zero gives 0.
- R4: An expander mask selects among input literals 0..7 only. The expander is the inverted AND of the literals it selects. An all-zero expander mask makes the expander 1.
- R5: The sum is the OR of the three product terms.
- R6: When the invert bit is 1, the output is the complement of the sum.
- R7: With the register-select bit 0, `f_out` follows `din` in the same cycle. With it set to 1, `f_out` shows the value the logic had at the last rising edge.
- R8: Using both expanders, the four-term function A'CD + B'CD + AB + BC' is built as (AB)'·CD + (A'C)'·B, where A..D are `din[0]`..`din[3]`.
- R9: The four-term function AB' + AC' + AD' + A'CD is built as the inverted three-term complement ABCD + A'D' + A'C'.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Macrocell clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_shift | input | 1 | Shift enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration bit |
| din | input | 4 | Data inputs A..D (bit 0 is A) |
| f_out | output | 1 | Macrocell output |

## Verification
In combinational mode `f_out` is due in the same cycle that `din` changes. The bench drives `din` on the falling edge and samples a quarter period later, before the next rising edge. In registered mode the value is due only after the next rising edge, so at the sample point between edges it still shows the previous result. The bench models this with a register of its own that it updates on the rising edge. A new configuration takes effect from the rising edge that shifts in its last bit. The reference chain is updated on that same edge, so every sample that follows compares against the new setting.

// File: rtl/mc_pkg.sv
// Shared sizes and the configuration record of the macrocell.
// Assumes expanders draw only on input literals, so there is no feedback loop.
package mc_pkg;
    localparam int N_IN   = 4;
    localparam int N_EXP  = 2;
    localparam int N_PT   = 3;
    localparam int XLIT_W = 2 * N_IN;
    localparam int LIT_W  = 2 * (N_IN + N_EXP);
    localparam int CFG_W  = N_PT * LIT_W + N_EXP * XLIT_W + 2;

    typedef struct packed {
        logic [N_PT-1:0][LIT_W-1:0]   pt_mask;
        logic [N_EXP-1:0][XLIT_W-1:0] exp_mask;
        logic                         invert;
        logic                         use_reg;
    } mc_cfg_t;
endpackage

// File: rtl/mc_cfg_chain.sv
// Serial configuration chain. The first bit shifted in ends at the MSB.
// Assumes loading happens while the output is not in use.
module mc_cfg_chain
    import mc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    shift_en,
    input  logic    bit_in,
    output mc_cfg_t cfg_o
);
    logic [CFG_W-1:0] chain_q;

    // Clear on reset, otherwise shift one bit in when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_q <= '0;
        else if (shift_en)
            chain_q <= {chain_q[CFG_W-2:0], bit_in};
    end

    assign cfg_o = mc_cfg_t'(chain_q);
endmodule

// File: rtl/mc_pterm.sv
// One AND-plane row: the AND of the literals picked by the fuse mask.
// An empty mask yields 0, so an unused row adds nothing to an OR.
module mc_pterm #(
    parameter int W = 8
) (
    input  logic [W-1:0] lits,
    input  logic [W-1:0] mask,
    output logic         term
);
    // Every selected literal must be 1, and at least one must be selected.
    always_comb term = (|mask) && (&(lits | ~mask));
endmodule

// File: rtl/mc_out_stage.sv
// Fixed OR of the product terms, programmable inversion and output register.
// Assumes the configuration is stable while in use.
module mc_out_stage #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] terms,
    input  logic         invert,
    input  logic         use_reg,
    output logic         comb_o,
    output logic         f_out
);
    logic reg_q;

    // OR the terms, then apply the programmed polarity.
    always_comb comb_o = (|terms) ^ invert;

    // Capture the logic value on every clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_q <= 1'b0;
        else
            reg_q <= comb_o;
    end

    // Pick the registered or the direct path.
    always_comb f_out = use_reg ? reg_q : comb_o;
endmodule

// File: rtl/mc_macrocell.sv
// Macrocell top: input literals, two expander rows fed back as literals,
// three product rows, then the output stage. Evaluation takes two passes
// through the plane: expanders first, then product terms.
module mc_macrocell
    import mc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_shift,
    input  logic            cfg_din,
    input  logic [N_IN-1:0] din,
    output logic            f_out
);
    mc_cfg_t           cfg_q;
    logic [XLIT_W-1:0] in_lits;
    logic [LIT_W-1:0]  all_lits;
    logic [N_EXP-1:0]  exp_prod;
    logic [N_EXP-1:0]  exp_vec;
    logic [N_PT-1:0]   pt_vec;
    logic              comb_val;

    mc_cfg_chain u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_shift),
        .bit_in   (cfg_din),
        .cfg_o    (cfg_q)
    );

    // True and complement literals of each input.
    for (genvar i = 0; i < N_IN; i++) begin : g_in_lit
        assign in_lits[2*i]   = din[i];
        assign in_lits[2*i+1] = ~din[i];
    end

    // First pass: expander rows, inverted and fed back.
    for (genvar j = 0; j < N_EXP; j++) begin : g_exp
        mc_pterm #(.W(XLIT_W)) u_exp (
            .lits (in_lits),
            .mask (cfg_q.exp_mask[j]),
            .term (exp_prod[j])
        );
        assign exp_vec[j]                  = ~exp_prod[j];
        assign all_lits[XLIT_W + 2*j]      = exp_vec[j];
        assign all_lits[XLIT_W + 2*j + 1]  = exp_prod[j];
    end
    assign all_lits[XLIT_W-1:0] = in_lits;

    // Second pass: product rows over inputs and expanders.
    for (genvar k = 0; k < N_PT; k++) begin : g_pt
        mc_pterm #(.W(LIT_W)) u_pt (
            .lits (all_lits),
            .mask (cfg_q.pt_mask[k]),
            .term (pt_vec[k])
        );
    end

    mc_out_stage #(.N(N_PT)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .terms   (pt_vec),
        .invert  (cfg_q.invert),
        .use_reg (cfg_q.use_reg),
        .comb_o  (comb_val),
        .f_out   (f_out)
    );
endmodule

// File: rtl/mc_macrocell_chk.sv
// Property checker for the macrocell, attached to every instance by bind.
module mc_macrocell_chk
    import mc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_shift,
    input logic             cfg_din,
    input logic             f_out,
    input mc_cfg_t          cfg_q,
    input logic [N_PT-1:0]  pt_vec,
    input logic [N_EXP-1:0] exp_vec,
    input logic             comb_val
);
    // R2: a shift enters the new bit at the bottom of the chain.
    a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shift |=> (cfg_q[0] == $past(cfg_din)));

    // R2: with shifting off, the configuration holds.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_shift && $past(rst_n)) |=> $stable(cfg_q));

    // R3: an empty product mask gives a 0 term.
    for (genvar k = 0; k < N_PT; k++) begin : g_pt_chk
        a_r3_empty_term: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q.pt_mask[k] == '0) |-> !pt_vec[k]);
    end

    // R4: an empty expander mask gives an expander of 1.
    for (genvar j = 0; j < N_EXP; j++) begin : g_exp_chk
        a_r4_empty_exp: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q.exp_mask[j] == '0) |-> exp_vec[j]);
    end

    // R7: in registered mode the output is the logic value one edge back.
    a_r7_reg_path: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cfg_q.use_reg) |-> (f_out == $past(comb_val)));
endmodule

bind mc_macrocell mc_macrocell_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_shift (cfg_shift),
    .cfg_din   (cfg_din),
    .f_out     (f_out),
    .cfg_q     (cfg_q),
    .pt_vec    (pt_vec),
    .exp_vec   (exp_vec),
    .comb_val  (comb_val)
);

// File: tb/test_mc_macrocell.sv
// Bench: behavioural reference compared every cycle, plus direct checks
// against the two four-term example functions.
module test_mc_macrocell;
    import mc_pkg::*;
    localparam int CLK_P = 10;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            cfg_shift;
    logic            cfg_din;
    logic [N_IN-1:0] din;
    logic            f_out;

    always #(CLK_P/2) clk = ~clk;

    mc_macrocell i_mc_macrocell (
        .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift),
        .cfg_din(cfg_din), .din(din), .f_out(f_out)
    );

    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;
    string tag   = "R1";

    logic [CFG_W-1:0] m_cfg;
    logic             m_q;

    // Reference: evaluate a configuration vector on an input word.
    function automatic logic ref_eval(logic [CFG_W-1:0] c, logic [N_IN-1:0] d);
        logic [LIT_W-1:0] lit;
        logic sum;
        for (int i = 0; i < N_IN; i++) begin
            lit[2*i] = d[i];
            lit[2*i+1] = !d[i];
        end
        for (int j = 0; j < N_EXP; j++) begin
            logic [XLIT_W-1:0] m;
            logic p;
            m = c[2 + XLIT_W*j +: XLIT_W];
            p = (m != 0);
            for (int b = 0; b < XLIT_W; b++) if (m[b] && !lit[b]) p = 0;
            lit[XLIT_W + 2*j] = !p;
            lit[XLIT_W + 2*j + 1] = p;
        end
        sum = 0;
        for (int k = 0; k < N_PT; k++) begin
            logic [LIT_W-1:0] m;
            logic p;
            m = c[2 + N_EXP*XLIT_W + LIT_W*k +: LIT_W];
            p = (m != 0);
            for (int b = 0; b < LIT_W; b++) if (m[b] && !lit[b]) p = 0;
            sum = sum | p;
        end
        return sum ^ c[1];
    endfunction

    function automatic logic f_exp(logic [3:0] d);
        return (!d[0] & d[2] & d[3]) | (!d[1] & d[2] & d[3]) | (d[0] & d[1]) | (d[1] & !d[2]);
    endfunction

    function automatic logic f_inv(logic [3:0] d);
        return (d[0] & !d[1]) | (d[0] & !d[2]) | (d[0] & !d[3]) | (!d[0] & d[2] & d[3]);
    endfunction

    // Reference state advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = '0;
            m_q = 1'b0;
        end else begin
            m_q = ref_eval(m_cfg, din);
            if (cfg_shift) m_cfg = {m_cfg[CFG_W-2:0], cfg_din};
        end
    end

    task automatic check(input logic got, input logic exp, input string r);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%b exp=%b din=%h t=%0t", r, got, exp, din, $time);
        end
    endtask

    // Per-cycle comparison a quarter period after the falling edge.
    always @(negedge clk) begin
        #(CLK_P/4);
        if (!done)
            check(f_out, m_cfg[0] ? m_q : ref_eval(m_cfg, din), tag);
    end

    task automatic load_cfg(input logic [CFG_W-1:0] v);
        for (int i = CFG_W-1; i >= 0; i--) begin
            @(negedge clk);
            cfg_shift = 1'b1;
            cfg_din = v[i];
        end
        @(negedge clk);
        cfg_shift = 1'b0;
        cfg_din = 1'b0;
    endtask

    function automatic logic [CFG_W-1:0] put_pt(logic [CFG_W-1:0] v, int k, logic [LIT_W-1:0] m);
        v[2 + N_EXP*XLIT_W + LIT_W*k +: LIT_W] = m;
        return v;
    endfunction

    function automatic logic [CFG_W-1:0] put_exp(logic [CFG_W-1:0] v, int j, logic [XLIT_W-1:0] m);
        v[2 + XLIT_W*j +: XLIT_W] = m;
        return v;
    endfunction

    task automatic sweep();
        for (int v = 0; v < 16; v++) begin
            @(negedge clk);
            din = v[3:0];
        end
    endtask

    logic [CFG_W-1:0] cfg_a, cfg_b, cfg_c, cfg_d;

    initial begin
        rst_n = 1'b0; cfg_shift = 1'b0; cfg_din = 1'b0; din = '0;
        tag = "R1";
        repeat (3) @(negedge clk);
        #(CLK_P/4);
        check(f_out, 1'b0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        sweep();

        // R3: single term A & ~C (literals 0 and 5).
        cfg_a = put_pt('0, 0, 12'b0000_0010_0001);
        tag = "R2"; load_cfg(cfg_a);
        tag = "R3"; sweep();
        for (int v = 0; v < 4; v++) begin
            @(negedge clk); din = v[3:0] ^ 4'b0101; #(CLK_P/4);
            check(f_out, din[0] & !din[2], "R3");
        end

        // R5: three terms A, B, C.
        cfg_b = put_pt(put_pt(put_pt('0, 0, 12'h001), 1, 12'h004), 2, 12'h010);
        tag = "R2"; load_cfg(cfg_b);
        tag = "R5";
        for (int v = 0; v < 16; v++) begin
            @(negedge clk); din = v[3:0]; #(CLK_P/4);
            check(f_out, din[0] | din[1] | din[2], "R5");
        end

        // R4, R8: expanders e0=(AB)', e1=(A'C)'; pt0=e0 C D, pt1=e1 B.
        cfg_c = put_exp(put_exp('0, 0, 8'b0000_0101), 1, 8'b0001_0010);
        cfg_c = put_pt(put_pt(cfg_c, 0, 12'b0001_0101_0000), 1, 12'b0100_0000_0100);
        tag = "R2"; load_cfg(cfg_c);
        tag = "R4";
        for (int v = 0; v < 16; v++) begin
            @(negedge clk); din = v[3:0]; #(CLK_P/4);
            check(f_out, f_exp(din), "R8");
        end

        // R2: hold while cfg_din toggles with shifting off.
        tag = "R2";
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); cfg_din = i[0]; din = i[3:0];
        end
        for (int v = 0; v < 16; v++) begin
            @(negedge clk); din = v[3:0]; #(CLK_P/4);
            check(f_out, f_exp(din), "R2");
        end

        // R6, R9: complement ABCD + A'D' + A'C', inverted.
        cfg_d = put_pt(put_pt(put_pt('0, 0, 12'b0000_0101_0101), 1, 12'b0000_1000_0010),
                       2, 12'b0000_0010_0010);
        cfg_d[1] = 1'b1;
        tag = "R2"; load_cfg(cfg_d);
        tag = "R6";
        for (int v = 0; v < 16; v++) begin
            @(negedge clk); din = v[3:0]; #(CLK_P/4);
            check(f_out, f_inv(din), "R9");
        end

        // R7: same function through the register.
        cfg_d[0] = 1'b1;
        tag = "R2"; load_cfg(cfg_d);
        tag = "R7"; sweep();
        for (int v = 0; v < 16; v++) begin
            logic [3:0] prev;
            prev = din;
            @(negedge clk); din = v[3:0]; #(CLK_P/4);
            check(f_out, f_inv(prev), "R7");
            @(posedge clk); #(CLK_P/4);
            check(f_out, f_inv(v[3:0]), "R7");
        end

        // R1: mid-run reset clears register and configuration.
        tag = "R1";
        @(negedge clk); rst_n = 1'b0; din = 4'b0001;
        @(negedge clk); #(CLK_P/4);
        check(f_out, 1'b0, "R1");
        @(negedge clk); rst_n = 1'b1;
        for (int v = 0; v < 16; v++) begin
            @(negedge clk); din = v[3:0]; #(CLK_P/4);
            check(f_out, 1'b0, "R1");
        end

        @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule